// File: doc/BRIEF.md
# Physical Register Budget Tracker

This block keeps count of how many physical entries are occupied in each of several physical register files while a core renames instructions. Each logical destination register has one owning file and a cost in physical entries; a double-width register, for instance, costs two. File 0 is special: it sees every logical register, so each write is charged to file 0 as well as to its owner. The owner and cost table comes from parameters and is loaded into registers at reset.

A rename request presents a logical destination. The block looks up its owner and cost, compares the current counts against each file's capacity, and returns a busy mask with one bit per file. An all-zero mask means the request fits. In that case the rename port is ready, and a request offered with valid is taken on that clock edge and its cost is charged. A write marked as a zero idiom needs no physical entry: it is always accepted and charged nothing. A retiring write gives its cost back to the same files. A capacity of zero marks a file as unbounded.

The rename port uses valid/ready. Ready is a combinational function of the request payload (register and zero-idiom flag) and the current counts. It never depends on valid. While valid is high and ready is low, the sender must hold the payload steady. A request is accepted only on an edge where both are high. The retire port is a plain pulse and is always accepted. The per-file counts are brought out as a plain status vector.

Top module: `prf_budget_tracker`

## Requirements
- R1: Reset sets every per-file used count to zero and loads the owner and cost table from the parameters.
- R2: Busy bit f is set exactly when file f is involved in the request, its capacity is nonzero, and the current used count plus the request cost exceeds that capacity. File 0 is involved in every request; the owning file is the other one. The bit is evaluated combinationally on the counts as they stood at the last edge. A bounded file's count never exceeds its capacity.
- R3: A file whose capacity parameter is zero never raises its busy bit, whatever its count.
- R4: ren_ready is high exactly when the busy mask is all zero. When ren_valid and ren_ready are both high at an edge, the cost is added to the owning file and to file 0, once only when the owner is file 0.
- R5: A rename request offered while ren_ready is low changes no count.
- R6: A rename request with ren_zero high shows an all-zero busy mask and charges no file.
- R7: A retire pulse subtracts the register's cost from its owning file and from file 0. A retire with ret_zero high subtracts nothing.
- R8: An accepted rename and a retire in the same cycle are applied together, so each count moves by the net amount.
- R9: A release never drives a count below zero, and a count never wraps above its maximum value; both clamp.
- R10: OWNER_MAP and COST_MAP hold one 8-bit field per logical register, with register i in bits [8i+7:8i]. The low bits of each field give the owning file index or the cost. FILE_CAP holds one 16-bit capacity per file, with file f in bits [16f+15:16f].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Request fits in every involved file |
| ren_reg | input | LREG_W | Logical destination of the rename request |
| ren_zero | input | 1 | Rename request is a zero idiom |
| ren_busy | output | NUM_FILES | Per-file busy mask for the presented request |
| ret_valid | input | 1 | Retire pulse |
| ret_reg | input | LREG_W | Logical destination of the retiring write |
| ret_zero | input | 1 | Retiring write was a zero idiom |
| used_o | output | NUM_FILES*CNT_W | Per-file used counts, file f in bits [CNT_W*f +: CNT_W] |

## Verification
The bench keeps the default table and four files. It overrides the capacities: file 0 gets 10, file 1 gets 3, file 2 gets 4, and file 3 gets 0 (unbounded). With limits this small, a handful of renames fills file 1 with single-cost registers and file 2 with two double-cost registers. File 0 then fills while the unbounded file 3 keeps growing. This brings each busy bit, the shared-file limit, and the rejection path into reach within a few cycles. Releases past empty then exercise the clamp at zero.

// File: rtl/prf_budget_pkg.sv
package prf_budget_pkg;

  // Field widths used to pack the configuration parameters.
  localparam int MAP_FIELD_W = 8;
  localparam int CAP_FIELD_W = 16;
  localparam int MAX_FILES   = 32;

  // Net count update with clamping at zero and at the counter ceiling.
  function automatic int unsigned clamp_net(input int unsigned base,
                                            input int unsigned add,
                                            input int unsigned sub,
                                            input int unsigned ceil);
    int signed t;
    t = int'(base) + int'(add) - int'(sub);
    if (t < 0) return 0;
    if (t > int'(ceil)) return ceil;
    return int'(t);
  endfunction

endpackage

// File: rtl/prf_cost_map.sv
module prf_cost_map #(
  parameter int NUM_LREGS = 16,
  parameter int NUM_FILES = 4,
  parameter int COST_W    = 2,
  parameter logic [NUM_LREGS*8-1:0] OWNER_MAP = '0,
  parameter logic [NUM_LREGS*8-1:0] COST_MAP  = '0,
  localparam int LREG_W = $clog2(NUM_LREGS),
  localparam int FIDX_W = $clog2(NUM_FILES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LREG_W-1:0] a_reg,
  output logic [FIDX_W-1:0] a_owner,
  output logic [COST_W-1:0] a_cost,
  input  logic [LREG_W-1:0] b_reg,
  output logic [FIDX_W-1:0] b_owner,
  output logic [COST_W-1:0] b_cost
);
  import prf_budget_pkg::*;

  logic [FIDX_W-1:0] owner_q [NUM_LREGS];
  logic [COST_W-1:0] cost_q  [NUM_LREGS];

  // Table entries are loaded from the parameters while reset is held.
  for (genvar i = 0; i < NUM_LREGS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        owner_q[i] <= OWNER_MAP[i*MAP_FIELD_W +: FIDX_W];
        cost_q[i]  <= COST_MAP[i*MAP_FIELD_W +: COST_W];
      end
    end
  end

  always_comb begin
    a_owner = owner_q[a_reg];
    a_cost  = cost_q[a_reg];
    b_owner = owner_q[b_reg];
    b_cost  = cost_q[b_reg];
  end

endmodule

// File: rtl/prf_charge_decode.sv
module prf_charge_decode #(
  parameter int NUM_FILES = 4,
  parameter int COST_W    = 2,
  localparam int FIDX_W = $clog2(NUM_FILES)
) (
  input  logic              en,
  input  logic [FIDX_W-1:0] owner,
  input  logic [COST_W-1:0] cost,
  output logic [COST_W-1:0] charge [NUM_FILES]
);
  // File 0 is charged for every write; another file only when it owns the register.
  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    if (f == 0) begin : g_shared
      assign charge[f] = en ? cost : '0;
    end else begin : g_owned
      assign charge[f] = (en && owner == FIDX_W'(f)) ? cost : '0;
    end
  end
endmodule

// File: rtl/prf_file_slot.sv
module prf_file_slot #(
  parameter int CAP    = 0,
  parameter int CNT_W  = 6,
  parameter int COST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COST_W-1:0] need,
  input  logic              take,
  input  logic [COST_W-1:0] give_back,
  output logic [CNT_W-1:0]  used,
  output logic              busy
);
  import prf_budget_pkg::*;

  localparam int unsigned CEIL = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] used_q;
  logic [CNT_W:0]   demand;

  assign demand = {1'b0, used_q} + (CNT_W+1)'(need);

  if (CAP == 0) begin : g_unbounded
    assign busy = 1'b0;
  end else begin : g_bounded
    assign busy = (need != '0) && (int'(demand) > CAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else used_q <= CNT_W'(clamp_net(int'(used_q),
                                    take ? int'(need) : 0,
                                    int'(give_back),
                                    CEIL));
  end

  assign used = used_q;

endmodule

// File: rtl/prf_budget_tracker.sv
module prf_budget_tracker #(
  parameter int NUM_FILES = 4,
  parameter int NUM_LREGS = 16,
  parameter int CNT_W     = 6,
  parameter int COST_W    = 2,
  parameter logic [NUM_LREGS*8-1:0] OWNER_MAP = 128'h00030303_02020202_01010101_01010101,
  parameter logic [NUM_LREGS*8-1:0] COST_MAP  = 128'h01010101_02020202_01010101_01010101,
  parameter logic [NUM_FILES*16-1:0] FILE_CAP = 64'h0004_0008_0006_0000,
  localparam int LREG_W = $clog2(NUM_LREGS),
  localparam int FIDX_W = $clog2(NUM_FILES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ren_valid,
  output logic                       ren_ready,
  input  logic [LREG_W-1:0]          ren_reg,
  input  logic                       ren_zero,
  output logic [NUM_FILES-1:0]       ren_busy,
  input  logic                       ret_valid,
  input  logic [LREG_W-1:0]          ret_reg,
  input  logic                       ret_zero,
  output logic [NUM_FILES*CNT_W-1:0] used_o
);
  import prf_budget_pkg::*;

  logic [FIDX_W-1:0] ren_owner, ret_owner;
  logic [COST_W-1:0] ren_cost, ret_cost;
  logic [COST_W-1:0] need   [NUM_FILES];
  logic [COST_W-1:0] refund [NUM_FILES];
  logic              accept;

  prf_cost_map #(
    .NUM_LREGS(NUM_LREGS), .NUM_FILES(NUM_FILES), .COST_W(COST_W),
    .OWNER_MAP(OWNER_MAP), .COST_MAP(COST_MAP)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .a_reg(ren_reg), .a_owner(ren_owner), .a_cost(ren_cost),
    .b_reg(ret_reg), .b_owner(ret_owner), .b_cost(ret_cost)
  );

  // Request demand is decoded from the payload alone; valid only gates the charge.
  prf_charge_decode #(.NUM_FILES(NUM_FILES), .COST_W(COST_W)) u_need (
    .en(!ren_zero), .owner(ren_owner), .cost(ren_cost), .charge(need)
  );

  prf_charge_decode #(.NUM_FILES(NUM_FILES), .COST_W(COST_W)) u_refund (
    .en(ret_valid && !ret_zero), .owner(ret_owner), .cost(ret_cost), .charge(refund)
  );

  assign ren_ready = (ren_busy == '0);
  assign accept    = ren_valid && ren_ready;

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_slot
    prf_file_slot #(
      .CAP(int'(FILE_CAP[f*CAP_FIELD_W +: CAP_FIELD_W])),
      .CNT_W(CNT_W), .COST_W(COST_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .need(need[f]), .take(accept), .give_back(refund[f]),
      .used(used_o[f*CNT_W +: CNT_W]), .busy(ren_busy[f])
    );
  end

endmodule

// File: rtl/prf_budget_tracker_chk.sv
module prf_budget_tracker_chk #(
  parameter int NUM_FILES = 4,
  parameter int CNT_W     = 6,
  parameter int LREG_W    = 4,
  parameter logic [NUM_FILES*16-1:0] FILE_CAP = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ren_valid,
  input logic                       ren_ready,
  input logic [LREG_W-1:0]          ren_reg,
  input logic                       ren_zero,
  input logic [NUM_FILES-1:0]       ren_busy,
  input logic                       ret_valid,
  input logic [LREG_W-1:0]          ret_reg,
  input logic                       ret_zero,
  input logic [NUM_FILES*CNT_W-1:0] used_o
);
  // R1: first edge after reset release shows all counts cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> used_o == '0);

  // R5: a refused request with no retire leaves every count as it was
  a_r5_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && !ren_ready && !ret_valid |=> $stable(used_o));

  // R6: a zero idiom never reports a busy file
  a_r6_zero_idiom_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ren_zero |-> ren_busy == '0);

  // R7: an idle cycle leaves the counts unchanged
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_valid && !ret_valid |=> $stable(used_o));

  // R2: a bounded file never holds more than its capacity
  for (genvar f = 0; f < NUM_FILES; f++) begin : g_cap
    if (FILE_CAP[f*16 +: 16] != 16'd0) begin : g_b
      a_r2_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(used_o[f*CNT_W +: CNT_W]) <= int'(FILE_CAP[f*16 +: 16]));
    end
  end
endmodule

bind prf_budget_tracker prf_budget_tracker_chk #(
  .NUM_FILES(NUM_FILES), .CNT_W(CNT_W), .LREG_W(LREG_W), .FILE_CAP(FILE_CAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_reg(ren_reg), .ren_zero(ren_zero), .ren_busy(ren_busy),
  .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_zero(ret_zero), .used_o(used_o)
);

// File: tb/prf_budget_tracker_tb.sv
module prf_budget_tracker_tb;
  localparam int NF = 4;
  localparam int CW = 6;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_zero = 1'b0, ret_valid = 1'b0, ret_zero = 1'b0;
  logic [3:0] ren_reg = '0, ret_reg = '0;
  logic ren_ready;
  logic [NF-1:0] ren_busy;
  logic [NF*CW-1:0] used_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  prf_budget_tracker #(
    .FILE_CAP(64'h0000_0004_0003_000A)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_reg(ren_reg), .ren_zero(ren_zero), .ren_busy(ren_busy),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_zero(ret_zero), .used_o(used_o)
  );

  typedef struct packed {
    logic       rv; logic [3:0] rr; logic rz;
    logic       tv; logic [3:0] tr; logic tz;
    logic       rdy; logic [3:0] mask;
    logic [5:0] u0, u1, u2, u3;
  } vec_t;

  // Caps: f0=10, f1=3, f2=4, f3 unbounded. r0-7 f1 c1, r8-11 f2 c2, r12-14 f3 c1, r15 f0 c1.
  localparam vec_t VEC [NV] = '{
    '{1'b1,4'd0, 1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd1, 6'd1,6'd0,6'd0},
    '{1'b1,4'd1, 1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd2, 6'd2,6'd0,6'd0},
    '{1'b1,4'd2, 1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd3, 6'd3,6'd0,6'd0},
    '{1'b1,4'd3, 1'b0,1'b0,4'd0, 1'b0,1'b0,4'h2,6'd3, 6'd3,6'd0,6'd0},
    '{1'b1,4'd8, 1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd5, 6'd3,6'd2,6'd0},
    '{1'b1,4'd9, 1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd7, 6'd3,6'd4,6'd0},
    '{1'b1,4'd10,1'b0,1'b0,4'd0, 1'b0,1'b0,4'h4,6'd7, 6'd3,6'd4,6'd0},
    '{1'b1,4'd3, 1'b1,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd7, 6'd3,6'd4,6'd0},
    '{1'b1,4'd3, 1'b0,1'b1,4'd0, 1'b0,1'b0,4'h2,6'd6, 6'd2,6'd4,6'd0},
    '{1'b1,4'd3, 1'b0,1'b1,4'd1, 1'b0,1'b1,4'h0,6'd6, 6'd2,6'd4,6'd0},
    '{1'b1,4'd12,1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd7, 6'd2,6'd4,6'd1},
    '{1'b1,4'd13,1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd8, 6'd2,6'd4,6'd2},
    '{1'b1,4'd14,1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd9, 6'd2,6'd4,6'd3},
    '{1'b1,4'd15,1'b0,1'b0,4'd0, 1'b0,1'b1,4'h0,6'd10,6'd2,6'd4,6'd3},
    '{1'b1,4'd12,1'b0,1'b0,4'd0, 1'b0,1'b0,4'h1,6'd10,6'd2,6'd4,6'd3},
    '{1'b0,4'd0, 1'b0,1'b1,4'd15,1'b1,1'b0,4'h0,6'd10,6'd2,6'd4,6'd3},
    '{1'b0,4'd0, 1'b0,1'b1,4'd15,1'b0,1'b0,4'h0,6'd9, 6'd2,6'd4,6'd3},
    '{1'b0,4'd0, 1'b0,1'b1,4'd9, 1'b0,1'b0,4'h0,6'd7, 6'd2,6'd2,6'd3},
    '{1'b0,4'd0, 1'b0,1'b1,4'd8, 1'b0,1'b0,4'h0,6'd5, 6'd2,6'd0,6'd3},
    '{1'b0,4'd0, 1'b0,1'b1,4'd8, 1'b0,1'b0,4'h0,6'd3, 6'd2,6'd0,6'd3},
    '{1'b1,4'd8, 1'b0,1'b1,4'd12,1'b0,1'b1,4'h0,6'd4, 6'd2,6'd2,6'd2}
  };

  // Requirement tags covered by the table: R2 R3 R4 R5 R6 R7 R8 R9
  function automatic string row_req(input int i);
    case (i)
      3, 6: return "R2";
      14: return "R3";
      7: return "R6";
      8: return "R5";
      9, 20: return "R8";
      15, 16: return "R7";
      19: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt(input int f);
    return int'(used_o[f*CW +: CW]);
  endfunction

  task automatic check_counts(input string req, input int e0, input int e1,
                              input int e2, input int e3);
    check(cnt(0) == e0, req, "file0 used", cnt(0), e0);
    check(cnt(1) == e1, req, "file1 used", cnt(1), e1);
    check(cnt(2) == e2, req, "file2 used", cnt(2), e2);
    check(cnt(3) == e3, req, "file3 used", cnt(3), e3);
  endtask

  task automatic drive(input logic rv, input logic [3:0] rr, input logic rz,
                       input logic tv, input logic [3:0] tr, input logic tz);
    @(negedge clk);
    ren_valid = rv; ren_reg = rr; ren_zero = rz;
    ret_valid = tv; ret_reg = tr; ret_zero = tz;
    #2;
  endtask

  task automatic settle;
    @(posedge clk);
    #2;
    ren_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    // r1_reset_state: counts cleared, request for reg 0 fits
    check_counts("R1", 0, 0, 0, 0);
    check(ren_ready == 1'b1, "R1", "ready after reset", ren_ready, 1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rv, VEC[i].rr, VEC[i].rz, VEC[i].tv, VEC[i].tr, VEC[i].tz);
      if (VEC[i].rv) begin
        check(ren_busy == VEC[i].mask, row_req(i), "busy mask", ren_busy, VEC[i].mask);
        check(ren_ready == VEC[i].rdy, row_req(i), "ready", ren_ready, VEC[i].rdy);
      end
      settle();
      check_counts(row_req(i), VEC[i].u0, VEC[i].u1, VEC[i].u2, VEC[i].u3);
    end

    // R1: reset mid-run clears every count
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #2;
    check_counts("R1", 0, 0, 0, 0);

    // R10: reg 11 field says owner file 2, cost 2
    drive(1'b1, 4'd11, 1'b0, 1'b0, 4'd0, 1'b0);
    check(ren_busy == 4'h0, "R10", "busy mask r11", ren_busy, 0);
    settle();
    check_counts("R10", 2, 0, 2, 0);

    // R9: release into an empty file 1 clamps at zero, file 0 goes 2 -> 1
    drive(1'b0, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0);
    settle();
    check_counts("R9", 1, 0, 2, 0);

    // R4: owner file 0 register charges file 0 once only
    drive(1'b1, 4'd15, 1'b0, 1'b0, 4'd0, 1'b0);
    check(ren_ready == 1'b1, "R4", "ready r15", ren_ready, 1);
    settle();
    check_counts("R4", 2, 0, 2, 0);

    // R5: a request held without valid charges nothing
    drive(1'b0, 4'd9, 1'b0, 1'b0, 4'd0, 1'b0);
    settle();
    check_counts("R5", 2, 0, 2, 0);

    finish_run();
  end
endmodule